// File: doc/BRIEF.md
# Workspace Register Cache

This block holds a CPU's sixteen working registers as a small on-chip cache of a register window that really lives in main memory. A workspace pointer gives the byte address of register 0; register n sits two bytes further on for each step of n. The CPU reads and writes registers through a single read port and a single write port. Every register write updates the local copy and is also sent to memory, so memory always holds the current window.

A context switch is a single load of the workspace pointer. That load marks every local copy stale. The block saves nothing and restores nothing at that point. A later read of a stale register stalls the CPU while the block fetches that word over the memory port. The read then completes from the refilled copy.

The memory port is a request/acknowledge pair. One request is in flight at a time, and the request fields stay fixed until the acknowledge arrives. The CPU holds its requests steady for as long as `stall` is high. A request counts as performed at a rising clock edge where `stall` is low.

Top module: `workspace_regcache`

## Requirements
- R1: After reset `stall` and `mem_req` are low, the workspace pointer is zero and every register is stale, so the first read of register n fetches byte address 2n.
- R2: Every memory request for register n carries byte address pointer + 2n, which is even and lies inside the current 16-register window.
- R3: A workspace pointer load is taken in any cycle where the memory port is idle. It marks all sixteen registers stale at that edge, and later reads fetch from the new base.
- R4: In a cycle where `wp_load` is taken, any read or write presented alongside it is discarded. No memory write is issued, and the register stays stale.
- R5: A read of a stale register raises `stall` in that same cycle and issues exactly one memory read. When the acknowledge arrives the fetched word is stored and marked valid, and `stall` then drops with the word on `rd_data`.
- R6: A read of a valid register returns its data in the same cycle, with no stall and no memory traffic.
- R7: A write, whether the register was valid or stale, updates and validates the register without stalling when the port is idle. It issues one memory write of `wr_data` to pointer + 2n.
- R8: While a memory request is outstanding, any read, write or pointer load presented to the block sees `stall` high.
- R9: A read and a write of the same register in one cycle return the new write data on `rd_data`, with no miss.
- R10: If a read misses while a write to another register is presented in the same cycle, the write is held. Its memory write is issued only after the read's fill has completed.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_load | input | 1 | Load a new workspace pointer |
| wp_value | input | 16 | New workspace base byte address |
| rd_en | input | 1 | Register read request |
| rd_idx | input | 4 | Register number to read |
| rd_data | output | 16 | Read data, valid when rd_en is high and stall is low |
| wr_en | input | 1 | Register write request |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 16 | Write data |
| stall | output | 1 | CPU must hold its request this cycle |
| mem_req | output | 1 | Memory request outstanding |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | 16 | Byte address of the request |
| mem_wdata | output | 16 | Write data of the request |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completes this cycle |

## Verification
The assertions check several properties on every cycle:
- requests hold steady until they are acknowledged;
- a busy port always stalls the CPU;
- request addresses stay inside the current window;
- a completed fill is never followed straight away by another request;
- a pointer load leaves every entry stale;
- same-register forwarding returns the write data.

Other behaviours span several operations, so only the directed scenarios can show them:
- a refilled word comes from the right base after a context switch;
- write-through data is still there when the old window is loaded again;
- a write alongside a pointer load is dropped;
- a write held behind a miss reaches memory only after the fill.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  // Memory port sequencer states
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_FILL  = 2'd1,
    PORT_WRITE = 2'd2
  } port_state_e;

endpackage

// File: rtl/wsc_addr_gen.sv
// Workspace pointer register and byte address formation: base + 2*idx.
module wsc_addr_gen #(
  parameter int AW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_take,
  input  logic [AW-1:0] wp_value,
  input  logic [IW-1:0] reg_idx,
  output logic [AW-1:0] wp_q,
  output logic [AW-1:0] reg_addr
);

  logic [AW-1:0] wp_d;
  logic [AW-1:0] offset;

  always_comb begin
    wp_d = wp_q;
    if (wp_take) wp_d = wp_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wp_q <= '0;
    else if (wp_take) wp_q <= wp_d;
  end

  assign offset   = {{(AW-IW-1){1'b0}}, reg_idx, 1'b0};
  assign reg_addr = wp_q + offset;

endmodule

// File: rtl/wsc_regfile.sv
// Cached register storage with per-entry valid bits and write forwarding.
module wsc_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 16,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_take,
  input  logic          wr_fwd,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic [DW-1:0] fill_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_hit
);

  logic [NREG-1:0] valid_q;
  logic [NREG-1:0] valid_d;
  logic            valid_en;
  logic [NREG-1:0] wr_dec;
  logic [NREG-1:0] fill_dec;
  logic [NREG-1:0] load;
  logic [DW-1:0]   load_data;
  logic [DW-1:0]   store_q [NREG];
  logic            same_idx;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_dec
    assign wr_dec[gi]   = wr_take && (wr_idx == IW'(gi));
    assign fill_dec[gi] = fill_en && (fill_idx == IW'(gi));
    assign load[gi]     = wr_dec[gi] | fill_dec[gi];
  end

  assign load_data = wr_take ? wr_data : fill_data;

  // valid bits: next state
  always_comb begin
    valid_en = clr | wr_take | fill_en;
    if (clr) valid_d = '0;
    else     valid_d = valid_q | wr_dec | fill_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid_q <= '0;
    else if (valid_en) valid_q <= valid_d;
  end

  // data storage, per-entry clock enable, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (load[i]) store_q[i] <= load_data;
    end
  end

  assign same_idx = wr_fwd && (wr_idx == rd_idx);
  assign rd_hit   = valid_q[rd_idx] | same_idx;
  assign rd_data  = same_idx ? wr_data : store_q[rd_idx];

  // R3: a pointer load leaves every entry stale at the next cycle
  assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (valid_q == '0));

endmodule

// File: rtl/wsc_mem_ctrl.sv
// Single-outstanding memory port: miss fill and write-through.
module wsc_mem_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_fill,
  input  logic          start_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [IW-1:0] req_idx,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          fill_en,
  output logic [IW-1:0] fill_idx,
  output logic [DW-1:0] fill_data
);

  import wsc_pkg::*;

  port_state_e   state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          cap_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    idx_d   = idx_q;
    cap_en  = 1'b0;
    case (state_q)
      PORT_IDLE: begin
        if (start_fill) begin
          state_d = PORT_FILL;
          cap_en  = 1'b1;
        end else if (start_write) begin
          state_d = PORT_WRITE;
          cap_en  = 1'b1;
        end
        addr_d  = req_addr;
        wdata_d = req_wdata;
        idx_d   = req_idx;
      end
      PORT_FILL:  if (mem_ack) state_d = PORT_IDLE;
      PORT_WRITE: if (mem_ack) state_d = PORT_IDLE;
      default:    state_d = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PORT_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      idx_q   <= '0;
    end else if (cap_en) begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      idx_q   <= idx_d;
    end
  end

  assign mem_req   = (state_q != PORT_IDLE);
  assign mem_we    = (state_q == PORT_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign busy      = mem_req;
  assign fill_en   = (state_q == PORT_FILL) && mem_ack;
  assign fill_idx  = idx_q;
  assign fill_data = mem_rdata;

  // R11: request fields hold until acknowledged
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata)));

  // R5: a completed fill issues no follow-on request in the next cycle
  assert_single_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> !mem_req);

endmodule

// File: rtl/workspace_regcache.sv
module workspace_regcache #(
  parameter int NREG = 16,
  parameter int DW   = 16,
  parameter int AW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_load,
  input  logic [AW-1:0] wp_value,
  input  logic          rd_en,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          stall,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);

  localparam int IW = $clog2(NREG);
  localparam int WINDOW_BYTES = 2 * NREG;

  logic          busy;
  logic          wp_take;
  logic          rd_hit;
  logic          rd_miss;
  logic          wr_take;
  logic          start_fill;
  logic [IW-1:0] addr_idx;
  logic [AW-1:0] reg_addr;
  logic [AW-1:0] wp_q;
  logic          fill_en;
  logic [IW-1:0] fill_idx;
  logic [DW-1:0] fill_data;

  // acceptance and stall
  assign wp_take    = wp_load & ~busy;
  assign rd_miss    = rd_en & ~wp_load & ~rd_hit;
  assign stall      = busy | rd_miss;
  assign wr_take    = wr_en & ~wp_load & ~stall;
  assign start_fill = rd_miss & ~busy;
  assign addr_idx   = start_fill ? rd_idx : wr_idx;

  wsc_addr_gen #(.AW(AW), .IW(IW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_take  (wp_take),
    .wp_value (wp_value),
    .reg_idx  (addr_idx),
    .wp_q     (wp_q),
    .reg_addr (reg_addr)
  );

  wsc_regfile #(.NREG(NREG), .DW(DW), .IW(IW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (wp_take),
    .wr_take   (wr_take),
    .wr_fwd    (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_data (fill_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_hit    (rd_hit)
  );

  wsc_mem_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_fill  (start_fill),
    .start_write (wr_take),
    .req_addr    (reg_addr),
    .req_wdata   (wr_data),
    .req_idx     (addr_idx),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .fill_en     (fill_en),
    .fill_idx    (fill_idx),
    .fill_data   (fill_data)
  );

  // R8: an outstanding request stalls every CPU request
  assert_busy_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && (rd_en || wr_en || wp_load)) |-> stall);

  // R9: same-register read and write return the new data
  assert_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && (rd_idx == wr_idx) && !wp_load && !stall) |-> (rd_data == wr_data));

  // R2: requests stay even and inside the current window
  assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!mem_addr[0] && (AW'(mem_addr - wp_q) < AW'(WINDOW_BYTES))));

endmodule

// File: tb/tb_workspace_regcache.sv
`timescale 1ns/1ps
module tb_workspace_regcache;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wp_load;
  logic [15:0] wp_value;
  logic        rd_en;
  logic [3:0]  rd_idx;
  logic [15:0] rd_data;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [15:0] wr_data;
  logic        stall;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  workspace_regcache dut (
    .clk(clk), .rst_n(rst_n), .wp_load(wp_load), .wp_value(wp_value),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .stall(stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // memory model: word array, fixed latency, ack for one cycle
  logic [15:0] mem [0:1023];
  int lat;
  int cnt;
  int n_rd, n_wr;
  logic [15:0] last_addr;

  function automatic logic [15:0] init_word(int byte_addr);
    return 16'hA000 ^ 16'(byte_addr >> 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      cnt       <= 0;
      n_rd      <= 0;
      n_wr      <= 0;
      last_addr <= '0;
      for (int i = 0; i < 1024; i++) mem[i] <= 16'hA000 ^ 16'(i);
    end else if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        mem_ack   <= 1'b1;
        cnt       <= 0;
        last_addr <= mem_addr;
        if (mem_we) begin
          mem[mem_addr[10:1]] <= mem_wdata;
          n_wr <= n_wr + 1;
        end else begin
          mem_rdata <= mem[mem_addr[10:1]];
          n_rd <= n_rd + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one CPU cycle of request, held while stalled
  task automatic cpu_op(input bit rd, input logic [3:0] ri, input bit wr,
                        input logic [3:0] wi, input logic [15:0] wd,
                        input bit wl, input logic [15:0] wv,
                        output logic [15:0] data, output int sc);
    @(negedge clk);
    rd_en = rd; rd_idx = ri; wr_en = wr; wr_idx = wi; wr_data = wd;
    wp_load = wl; wp_value = wv;
    #1;
    sc = 0;
    while (stall) begin
      @(negedge clk); #1; sc++;
    end
    data = rd_data;
    @(posedge clk); #1;
    rd_en = 0; wr_en = 0; wp_load = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mem_req) @(negedge clk);
  endtask

  logic [15:0] d;
  int sc, rd0, wr0;

  task automatic t_reset();
    @(negedge clk);
    chk(stall == 0, "R1 stall after reset", stall, 0);
    chk(mem_req == 0, "R1 mem_req after reset", mem_req, 0);
    rd0 = n_rd;
    cpu_op(1, 4'd4, 0, 0, 0, 0, 0, d, sc);
    chk(d == init_word(8), "R1 first read from base zero", d, init_word(8));
    chk(n_rd == rd0 + 1 && last_addr == 16'h0008, "R1 fetch address 2n", last_addr, 8);
  endtask

  task automatic t_miss_fill();
    lat = 0;
    cpu_op(0, 0, 0, 0, 0, 1, 16'h0100, d, sc);
    rd0 = n_rd;
    cpu_op(1, 4'd3, 0, 0, 0, 0, 0, d, sc);
    chk(d == init_word(16'h106), "R5 miss data", d, init_word(16'h106));
    chk(sc >= 1, "R5 miss stalls", sc, 1);
    chk(n_rd == rd0 + 1, "R5 one memory read", n_rd - rd0, 1);
    chk(last_addr == 16'h0106, "R2 fill address", last_addr, 16'h0106);
    lat = 2;
  endtask

  task automatic t_hit();
    rd0 = n_rd;
    cpu_op(1, 4'd3, 0, 0, 0, 0, 0, d, sc);
    chk(sc == 0, "R6 hit no stall", sc, 0);
    chk(d == init_word(16'h106), "R6 hit data", d, init_word(16'h106));
    @(negedge clk);
    chk(n_rd == rd0, "R6 hit no traffic", n_rd - rd0, 0);
  endtask

  task automatic t_write();
    wr0 = n_wr; rd0 = n_rd;
    cpu_op(0, 0, 1, 4'd5, 16'h1234, 0, 0, d, sc);
    chk(sc == 0, "R7 write no stall", sc, 0);
    wait_idle();
    chk(mem[16'h10A >> 1] == 16'h1234, "R7 write-through data", mem[16'h10A >> 1], 16'h1234);
    chk(n_wr == wr0 + 1 && last_addr == 16'h010A, "R7 write address", last_addr, 16'h010A);
    cpu_op(1, 4'd5, 0, 0, 0, 0, 0, d, sc);
    chk(d == 16'h1234 && sc == 0 && n_rd == rd0, "R7 written entry valid", d, 16'h1234);
  endtask

  task automatic t_busy();
    cpu_op(0, 0, 1, 4'd1, 16'h1111, 0, 0, d, sc);
    chk(sc == 0, "R8 first write free", sc, 0);
    cpu_op(0, 0, 1, 4'd2, 16'h2222, 0, 0, d, sc);
    chk(sc >= 1, "R8 second write stalls while busy", sc, 1);
    wait_idle();
    chk(mem[16'h102 >> 1] == 16'h1111 && mem[16'h104 >> 1] == 16'h2222,
        "R8 both writes land", mem[16'h104 >> 1], 16'h2222);
  endtask

  task automatic t_forward();
    rd0 = n_rd; wr0 = n_wr;
    cpu_op(1, 4'd7, 1, 4'd7, 16'hBEEF, 0, 0, d, sc);
    chk(d == 16'hBEEF && sc == 0, "R9 forwarded data", d, 16'hBEEF);
    wait_idle();
    chk(n_rd == rd0 && n_wr == wr0 + 1, "R9 no fill, one write", n_rd - rd0, 0);
  endtask

  task automatic t_switch();
    cpu_op(0, 0, 0, 0, 0, 1, 16'h0200, d, sc);
    rd0 = n_rd;
    cpu_op(1, 4'd3, 0, 0, 0, 0, 0, d, sc);
    chk(d == init_word(16'h206) && n_rd == rd0 + 1, "R3 refill from new base", d, init_word(16'h206));
    cpu_op(1, 4'd5, 0, 0, 0, 0, 0, d, sc);
    chk(d == init_word(16'h20A) && sc >= 1, "R3 old entry stale", d, init_word(16'h20A));
    cpu_op(0, 0, 0, 0, 0, 1, 16'h0100, d, sc);
    cpu_op(1, 4'd5, 0, 0, 0, 0, 0, d, sc);
    chk(d == 16'h1234 && sc >= 1, "R3 old window kept in memory", d, 16'h1234);
  endtask

  task automatic t_discard();
    wr0 = n_wr;
    cpu_op(0, 0, 1, 4'd2, 16'hDEAD, 1, 16'h0300, d, sc);
    repeat (4) @(negedge clk);
    chk(n_wr == wr0 && mem[16'h304 >> 1] == init_word(16'h304), "R4 write discarded", n_wr - wr0, 0);
    rd0 = n_rd;
    cpu_op(1, 4'd2, 0, 0, 0, 0, 0, d, sc);
    chk(d == init_word(16'h304) && n_rd == rd0 + 1, "R4 entry still stale", d, init_word(16'h304));
  endtask

  task automatic t_held_write();
    wr0 = n_wr;
    cpu_op(1, 4'd8, 1, 4'd9, 16'h5A5A, 0, 0, d, sc);
    chk(n_wr == wr0, "R10 write held during fill", n_wr - wr0, 0);
    chk(d == init_word(16'h310) && sc >= 1, "R10 miss data", d, init_word(16'h310));
    wait_idle();
    chk(mem[16'h312 >> 1] == 16'h5A5A && n_wr == wr0 + 1, "R10 held write lands", mem[16'h312 >> 1], 16'h5A5A);
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; wp_load = 0; wp_value = 0; rd_en = 0; rd_idx = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0; lat = 2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_miss_fill();
    t_hit();
    t_write();
    t_busy();
    t_forward();
    t_switch();
    t_discard();
    t_held_write();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule